// File: doc/BRIEF.md
# Event Performance Counter Unit

The unit holds a small bank of event counters, each paired with a 32-bit control word. Software reaches both through a register port. The port picks a counter by index and picks either the counter or its control word. Every cycle the unit sees a vector of single-cycle event pulses, together with the current privilege state: an exception-level flag plus a two-bit privilege code. A counter advances by one in a cycle only when all three of these hold: the event its control word selects pulses, the active privilege state is enabled in that control word, and the thread filter in the control word accepts the current context and thread identifiers.

A counter counts as overflowed while its most significant bit is 1. Software arms a sampling period P by writing the value (2^(W-1) - P). The interrupt output is the OR over all counters of "top bit set and interrupt enable set". The same pending state shows as bit 26 of a cause-status output. A second hardware thread sees the counters with its indices rotated by half the bank, so both threads can use "counter 0" without sharing it.

Top module: `evt_ctr_unit`

## Requirements
- R1: After reset every counter reads 0 and every stored control field reads 0. The interrupt output is low and the cause output is 0.
- R2: Control bits 0–14 and 16–29 are writable and read back as written. Bit 15 always reads 0. Bit 30 reads 1 only when counters are 64 bits wide (0 at the default 32-bit width). Bit 31 reads 1 for every physical counter except the last.
- R3: Privilege gating. With the exception-level flag high, a counter counts only if control bit 0 is set. Otherwise privilege code 0 (user) needs bit 3, code 1 (supervisor) needs bit 2, code 2 (kernel) needs bit 1, and code 3 never counts.
- R4: The event selector is control bits 14:5. A counter counts in a cycle only when the selected event pulse is high. A selector at or above the number of event inputs never counts.
- R5: Control bits 21:20 pick a filter. 0 accepts all. 1 counts only when the context-id input equals bits 19:16. 2 counts only when the thread-id input equals bits 29:22. 3 never counts.
- R6: A counter write takes priority over an increment in the same cycle. A write or an increment shows on the read port in the cycle after the clock edge that applies it.
- R7: The interrupt output is high exactly when some counter has its top bit set and control bit 4 set. Cause bit 26 mirrors the interrupt, and all other cause bits read 0.
- R8: A counter keeps counting after its top bit sets. The top bit, and so the interrupt, stays set until software rewrites the counter with a value whose top bit is clear.
- R9: With the thread-select input high, logical index i reaches physical counter (i + 2) mod 4, for counter and control accesses and for reads and writes alike.
- R10: Clearing control bits 0–4 pauses the counter (its value holds) and drops its interrupt. Writing the saved control value back resumes counting and restores the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exl_i | input | 1 | Exception-level flag |
| priv_i | input | 2 | Privilege code: 0 user, 1 supervisor, 2 kernel, 3 none |
| ctx_id_i | input | 4 | Current context identifier |
| thr_id_i | input | 8 | Current thread identifier |
| ev_pulse_i | input | NUM_EVT | Event pulses for this cycle |
| reg_thread_i | input | 1 | Accessing thread: 0 direct, 1 rotated indices |
| reg_idx_i | input | log2(NUM_CTR) | Logical counter index |
| reg_is_ctl_i | input | 1 | 1 selects the control word, 0 selects the counter |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | CNT_W | Write data (control uses the low 32 bits) |
| reg_rdata_o | output | CNT_W | Read data for the selected register, combinational |
| irq_o | output | 1 | Overflow interrupt |
| cause_o | output | 32 | Cause status, bit 26 = counter interrupt pending |

## Verification
A write issued before a clock edge shows on the combinational read port straight after that edge. An event pulse held across one edge changes the counter by one at that same edge. The interrupt and cause outputs follow the registered counter and control state with no further delay. The bench therefore drives every input just after a rising edge, lets exactly one edge pass for each update, and samples reads and interrupt outputs in the quiet part of the following cycle. Each table vector isolates a single counting edge, so an expected step of 0 or 1 pins down exactly one gating decision.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;

    localparam int CTL_W       = 32;
    localparam int B_IE        = 4;
    localparam int B_EVT_LO    = 5;
    localparam int EVT_SEL_W   = 10;
    localparam int B_CTX_LO    = 16;
    localparam int CTX_W       = 4;
    localparam int B_FLT_LO    = 20;
    localparam int B_THR_LO    = 22;
    localparam int THR_W       = 8;
    localparam int B_WIDE      = 30;
    localparam int B_MORE      = 31;

    // bits software may set: 0..14 and 16..29
    localparam logic [CTL_W-1:0] CTL_WR_MASK = 32'h3FFF_7FFF;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_KERN  = 2'd2,
        PRIV_NONE  = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        FLT_ALL = 2'd0,
        FLT_CTX = 2'd1,
        FLT_THR = 2'd2,
        FLT_OFF = 2'd3
    } filt_e;

    function automatic logic mode_ok(input logic [CTL_W-1:0] ctl,
                                     input logic exl,
                                     input logic [1:0] priv);
        logic ok;
        if (exl) begin
            ok = ctl[0];
        end else begin
            case (priv_e'(priv))
                PRIV_USER:  ok = ctl[3];
                PRIV_SUPER: ok = ctl[2];
                PRIV_KERN:  ok = ctl[1];
                default:    ok = 1'b0;
            endcase
        end
        return ok;
    endfunction

    function automatic logic filter_ok(input logic [CTL_W-1:0] ctl,
                                       input logic [CTX_W-1:0] ctx,
                                       input logic [THR_W-1:0] thr);
        logic ok;
        case (filt_e'(ctl[B_FLT_LO +: 2]))
            FLT_ALL: ok = 1'b1;
            FLT_CTX: ok = (ctx == ctl[B_CTX_LO +: CTX_W]);
            FLT_THR: ok = (thr == ctl[B_THR_LO +: THR_W]);
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/evt_ctr_remap.sv
module evt_ctr_remap #(
    parameter int NUM_CTR = 4,
    localparam int IW     = $clog2(NUM_CTR),
    localparam int HALF   = NUM_CTR / 2
) (
    input  logic          thread_i,
    input  logic [IW-1:0] idx_i,
    output logic [IW-1:0] phys_o
);
    always_comb begin
        // modulo by truncation to IW bits
        phys_o = thread_i ? IW'(idx_i + IW'(HALF)) : idx_i;
    end
endmodule

// File: rtl/evt_ctr_slice.sv
module evt_ctr_slice
    import evt_ctr_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NUM_EVT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exl_i,
    input  logic [1:0]         priv_i,
    input  logic [CTX_W-1:0]   ctx_id_i,
    input  logic [THR_W-1:0]   thr_id_i,
    input  logic [NUM_EVT-1:0] ev_pulse_i,
    input  logic               wr_ctl_i,
    input  logic               wr_cnt_i,
    input  logic [CNT_W-1:0]   wdata_i,
    output logic [CNT_W-1:0]   cnt_o,
    output logic [CTL_W-1:0]   ctl_o,
    output logic               ovf_irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CTL_W-1:0] ctl;
    } slice_st_t;

    slice_st_t st_d, st_q;
    logic      ev_hit;
    logic      hit;

    always_comb begin
        ev_hit = 1'b0;
        for (int k = 0; k < NUM_EVT; k++) begin
            if (st_q.ctl[B_EVT_LO +: EVT_SEL_W] == EVT_SEL_W'(k))
                ev_hit = ev_pulse_i[k];
        end
        hit = ev_hit
            & mode_ok(st_q.ctl, exl_i, priv_i)
            & filter_ok(st_q.ctl, ctx_id_i, thr_id_i);

        st_d = st_q;
        if (wr_cnt_i)
            st_d.cnt = wdata_i;
        else if (hit)
            st_d.cnt = st_q.cnt + CNT_W'(1);
        if (wr_ctl_i)
            st_d.ctl = wdata_i[CTL_W-1:0] & CTL_WR_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o     = st_q.cnt;
    assign ctl_o     = st_q.ctl;
    assign ovf_irq_o = st_q.cnt[CNT_W-1] & st_q.ctl[B_IE];

    // R6
    cnt_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_i |=> st_q.cnt == $past(wdata_i));

    // R3
    cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt_i && hit) |=> st_q.cnt == CNT_W'($past(st_q.cnt) + CNT_W'(1)));

    // R10
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt_i && !hit) |=> $stable(st_q.cnt));

    // R2
    ctl_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctl[B_MORE] == 1'b0) && (st_q.ctl[B_WIDE] == 1'b0) && (st_q.ctl[15] == 1'b0));

    // R8
    msb_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt[CNT_W-1] && !wr_cnt_i && st_q.cnt != '1) |=> st_q.cnt[CNT_W-1]);
endmodule

// File: rtl/evt_ctr_irq.sv
module evt_ctr_irq #(
    parameter int NUM_CTR   = 4,
    parameter int CAUSE_BIT = 26
) (
    input  logic [NUM_CTR-1:0] ovf_i,
    output logic               irq_o,
    output logic [31:0]        cause_o
);
    always_comb begin
        irq_o            = |ovf_i;
        cause_o          = '0;
        cause_o[CAUSE_BIT] = irq_o;
    end
endmodule

// File: rtl/evt_ctr_unit.sv
module evt_ctr_unit
    import evt_ctr_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CNT_W   = 32,
    parameter int NUM_EVT = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       exl_i,
    input  logic [1:0]                 priv_i,
    input  logic [3:0]                 ctx_id_i,
    input  logic [7:0]                 thr_id_i,
    input  logic [NUM_EVT-1:0]         ev_pulse_i,
    input  logic                       reg_thread_i,
    input  logic [$clog2(NUM_CTR)-1:0] reg_idx_i,
    input  logic                       reg_is_ctl_i,
    input  logic                       reg_we_i,
    input  logic [CNT_W-1:0]           reg_wdata_i,
    output logic [CNT_W-1:0]           reg_rdata_o,
    output logic                       irq_o,
    output logic [31:0]                cause_o
);
    localparam int  IW      = $clog2(NUM_CTR);
    localparam logic IS_WIDE = (CNT_W == 64);

    logic [IW-1:0]      phys;
    logic [CNT_W-1:0]   cnt_arr [NUM_CTR];
    logic [CTL_W-1:0]   ctl_arr [NUM_CTR];
    logic [CTL_W-1:0]   ctl_view [NUM_CTR];
    logic [NUM_CTR-1:0] ovf;

    evt_ctr_remap #(.NUM_CTR(NUM_CTR)) u_remap (
        .thread_i (reg_thread_i),
        .idx_i    (reg_idx_i),
        .phys_o   (phys)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        logic sel;
        assign sel = (phys == IW'(g));

        evt_ctr_slice #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT)) u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .exl_i      (exl_i),
            .priv_i     (priv_i),
            .ctx_id_i   (ctx_id_i),
            .thr_id_i   (thr_id_i),
            .ev_pulse_i (ev_pulse_i),
            .wr_ctl_i   (reg_we_i & reg_is_ctl_i & sel),
            .wr_cnt_i   (reg_we_i & ~reg_is_ctl_i & sel),
            .wdata_i    (reg_wdata_i),
            .cnt_o      (cnt_arr[g]),
            .ctl_o      (ctl_arr[g]),
            .ovf_irq_o  (ovf[g])
        );

        always_comb begin
            ctl_view[g]         = ctl_arr[g];
            ctl_view[g][B_WIDE] = IS_WIDE;
            ctl_view[g][B_MORE] = (g != NUM_CTR - 1);
        end
    end

    always_comb begin
        if (reg_is_ctl_i) reg_rdata_o = CNT_W'(ctl_view[phys]);
        else              reg_rdata_o = cnt_arr[phys];
    end

    evt_ctr_irq #(.NUM_CTR(NUM_CTR), .CAUSE_BIT(26)) u_irq (
        .ovf_i   (ovf),
        .irq_o   (irq_o),
        .cause_o (cause_o)
    );

    // R7
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ovf != '0) && $onehot0(cause_o));
endmodule

// File: tb/evt_ctr_unit_test.sv
module evt_ctr_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exl_i = 1'b0;
    logic [1:0]  priv_i = 2'd0;
    logic [3:0]  ctx_id_i = 4'd0;
    logic [7:0]  thr_id_i = 8'd0;
    logic [15:0] ev_pulse_i = 16'd0;
    logic        reg_thread_i = 1'b0;
    logic [1:0]  reg_idx_i = 2'd0;
    logic        reg_is_ctl_i = 1'b0;
    logic        reg_we_i = 1'b0;
    logic [31:0] reg_wdata_i = 32'd0;
    logic [31:0] reg_rdata_o;
    logic        irq_o;
    logic [31:0] cause_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    evt_ctr_unit uut (.*);

    typedef struct packed {
        logic [31:0] ctl;
        logic        exl;
        logic [1:0]  priv;
        logic [15:0] ev;
        logic [3:0]  ctx;
        logic [7:0]  thr;
        logic        inc;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0068, 1'b0, 2'd0, 16'h0008, 4'd0, 8'h00, 1'b1, 4'd3}, // R3 user
        '{32'h0000_0068, 1'b0, 2'd0, 16'h0004, 4'd0, 8'h00, 1'b0, 4'd4}, // R4 other event
        '{32'h0000_0068, 1'b0, 2'd1, 16'h0008, 4'd0, 8'h00, 1'b0, 4'd3}, // R3 wrong mode
        '{32'h0000_0064, 1'b0, 2'd1, 16'h0008, 4'd0, 8'h00, 1'b1, 4'd3}, // R3 supervisor
        '{32'h0000_0062, 1'b0, 2'd2, 16'h0008, 4'd0, 8'h00, 1'b1, 4'd3}, // R3 kernel
        '{32'h0000_0062, 1'b1, 2'd2, 16'h0008, 4'd0, 8'h00, 1'b0, 4'd3}, // R3 exl overrides
        '{32'h0000_0061, 1'b1, 2'd0, 16'h0008, 4'd0, 8'h00, 1'b1, 4'd3}, // R3 exl
        '{32'h0000_006F, 1'b0, 2'd3, 16'h0008, 4'd0, 8'h00, 1'b0, 4'd3}, // R3 code 3
        '{32'h0000_0288, 1'b0, 2'd0, 16'hFFFF, 4'd0, 8'h00, 1'b0, 4'd4}, // R4 selector 20
        '{32'h0015_0068, 1'b0, 2'd0, 16'h0008, 4'd5, 8'h00, 1'b1, 4'd5}, // R5 ctx match
        '{32'h0015_0068, 1'b0, 2'd0, 16'h0008, 4'd4, 8'h00, 1'b0, 4'd5}, // R5 ctx miss
        '{32'h2960_0068, 1'b0, 2'd0, 16'h0008, 4'd0, 8'hA5, 1'b1, 4'd5}, // R5 thr match
        '{32'h2960_0068, 1'b0, 2'd0, 16'h0008, 4'd0, 8'hA4, 1'b0, 4'd5}, // R5 thr miss
        '{32'h0030_0068, 1'b0, 2'd0, 16'hFFFF, 4'd0, 8'h00, 1'b0, 4'd5}  // R5 filter off
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic th, input logic [1:0] idx, input logic is_ctl,
                      input logic [31:0] d);
        reg_thread_i = th; reg_idx_i = idx; reg_is_ctl_i = is_ctl;
        reg_wdata_i = d; reg_we_i = 1'b1;
        tick();
        reg_we_i = 1'b0;
    endtask

    task automatic rd(input logic th, input logic [1:0] idx, input logic is_ctl,
                      output logic [31:0] d);
        reg_thread_i = th; reg_idx_i = idx; reg_is_ctl_i = is_ctl; reg_we_i = 1'b0;
        #1;
        d = reg_rdata_o;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse();
        ev_pulse_i = 16'h0008;
        tick();
        ev_pulse_i = 16'h0000;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        rd(0, 0, 1, v); chk("R1", v, 32'h8000_0000);
        rd(0, 3, 1, v); chk("R1", v, 32'h0000_0000);
        rd(0, 1, 0, v); chk("R1", v, 32'h0);
        chk("R1", {31'd0, irq_o}, 32'd0);
        chk("R1", cause_o, 32'd0);

        // R2 writable mask on last counter
        wr(0, 3, 1, 32'hFFFF_FFFF);
        rd(0, 3, 1, v); chk("R2", v, 32'h3FFF_7FFF);
        wr(0, 3, 1, 32'h0);

        // table walk: one counting edge per vector
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            wr(0, 0, 1, VECS[i].ctl);
            wr(0, 0, 0, 32'd0);
            rd(0, 0, 1, v); chk("R2", v, VECS[i].ctl | 32'h8000_0000);
            exl_i = VECS[i].exl; priv_i = VECS[i].priv;
            ctx_id_i = VECS[i].ctx; thr_id_i = VECS[i].thr;
            ev_pulse_i = VECS[i].ev;
            tick();
            ev_pulse_i = 16'd0; exl_i = 1'b0; priv_i = 2'd0;
            rd(0, 0, 0, v); chk(tag, v, {31'd0, VECS[i].inc});
        end
        ctx_id_i = 4'd0; thr_id_i = 8'd0;

        // R6 write beats increment in same cycle
        wr(0, 0, 1, 32'h68);
        ev_pulse_i = 16'h0008;
        wr(0, 0, 0, 32'd100);
        rd(0, 0, 0, v); chk("R6", v, 32'd100);
        tick();
        ev_pulse_i = 16'h0000;
        rd(0, 0, 0, v); chk("R6", v, 32'd101);

        // R7 overflow on top bit
        wr(0, 0, 1, 32'h78);
        wr(0, 0, 0, 32'h7FFF_FFFF);
        chk("R7", {31'd0, irq_o}, 32'd0);
        pulse();
        rd(0, 0, 0, v); chk("R7", v, 32'h8000_0000);
        chk("R7", {31'd0, irq_o}, 32'd1);
        chk("R7", cause_o, 32'h0400_0000);
        // R8 keeps counting, stays flagged
        pulse();
        rd(0, 0, 0, v); chk("R8", v, 32'h8000_0001);
        chk("R8", {31'd0, irq_o}, 32'd1);

        // R10 pause and resume
        wr(0, 0, 1, 32'h60);
        chk("R10", {31'd0, irq_o}, 32'd0);
        pulse();
        rd(0, 0, 0, v); chk("R10", v, 32'h8000_0001);
        wr(0, 0, 1, 32'h78);
        chk("R10", {31'd0, irq_o}, 32'd1);
        pulse();
        rd(0, 0, 0, v); chk("R10", v, 32'h8000_0002);

        // R8 rewrite clears
        wr(0, 0, 0, 32'd5);
        chk("R8", {31'd0, irq_o}, 32'd0);
        chk("R8", cause_o, 32'd0);
        wr(0, 0, 1, 32'h0);

        // R9 thread rotation
        wr(1, 0, 0, 32'h0000_1234);
        rd(0, 2, 0, v); chk("R9", v, 32'h0000_1234);
        rd(0, 0, 0, v); chk("R9", v, 32'd5);
        wr(1, 1, 1, 32'h42);
        rd(0, 3, 1, v); chk("R9", v, 32'h42);
        rd(1, 1, 1, v); chk("R9", v, 32'h42);
        wr(0, 1, 1, 32'h11);
        rd(1, 3, 1, v); chk("R9", v, 32'h8000_0011);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule